// File: doc/BRIEF.md
# Memory Dependency Group Scoreboard

This block keeps a small table of memory groups for an out-of-order load/store scheduler. A group collects memory operations that wait on the same older operations and never on each other. For every group the block counts its predecessors in three states (total, issuing, finished) and its member operations in three states (total, issuing, complete). It also keeps two kinds of link to younger groups. An order link only asks that the younger group not start before this one. It is released when the last outstanding member of this group issues. A data link is held until every member of this group has completed.

The scheduler sends one event per cycle on a valid/ready channel: add a member, link two groups, a member issued, a member completed. From the counters the block derives five status flags for each group. It also keeps a per-group countdown estimating how long a waiting group still has to wait on its slowest issuing data predecessor. An event that would corrupt the counters is flagged and then dropped.

Top module: `mdg_scoreboard`

## Requirements
- R1: After reset every group has zero counts and no links, so all groups read ready and executed, none waiting, pending or executing, every countdown is 0, and `ev_ready` is low while `rst_n` is low and high from the first clock after its release.
- R2: Each group is in exactly one class: waiting when its predecessor total is larger than its issuing plus finished predecessors, pending when at least one predecessor is issuing and issuing plus finished equal the total, ready when finished predecessors equal the total.
- R3: A group is executing when its issued count is nonzero and equals members minus completed members (a partly issued group is not executing). It is executed when completed members equal members. The two are never both set.
- R4: When a group becomes executing, each order successor counts that predecessor as issued and then at once as finished. A successor whose only predecessor is that group reads ready, not pending, in the next cycle.
- R5: When a group becomes executing, each data successor counts one issuing predecessor (it goes pending). When the last member completes, that predecessor moves to finished.
- R6: An order link requested from a source that is already executing is accepted without error and changes nothing.
- R7: A data link requested from an already executing source adds a predecessor that already counts as issuing, and raises the target's countdown to the source's largest issued latency if that is larger.
- R8: Adding a member to a group that already has successor links is illegal: `ev_err` is high in that cycle and the group keeps its member count.
- R9: Also illegal and dropped, with `ev_err` high: a link from a group to itself, a second link between the same ordered pair, a link from an executed source, an issue to a group that is not ready or has nothing left to issue, a completion with no member issued, and an add that would overflow a member or predecessor count (limit 2^CW-1).
- R10: Each cycle, a waiting group whose countdown is nonzero decreases it by one. Countdowns of groups that are not waiting hold their value, and a countdown never goes below 0.
- R11: A group's largest issued latency is the maximum `ev_cycles` over its issued members. When it starts, data successors take the larger of their countdown and that maximum.
- R12: An event is taken in a cycle where `ev_valid` and `ev_ready` are both high. Its effect shows on the flags in the next cycle and `ev_err` is combinational in the same cycle. Opcode encoding on `ev_op`: 0 add member, 1 link (`ev_data` 1 = data, 0 = order, from `ev_grp` to `ev_dst`), 2 member issued (latency in `ev_cycles`), 3 member completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Block accepts an event this cycle |
| ev_op | input | 2 | Event opcode (see R12) |
| ev_grp | input | GW | Group the event targets, or link source |
| ev_dst | input | GW | Link target group |
| ev_data | input | 1 | Link kind: 1 data, 0 order |
| ev_cycles | input | LW | Latency of an issued member |
| ev_err | output | 1 | Accepted event is illegal and was dropped |
| grp_waiting | output | NG | Per-group waiting flag |
| grp_pending | output | NG | Per-group pending flag |
| grp_ready | output | NG | Per-group ready flag |
| grp_executing | output | NG | Per-group executing flag |
| grp_executed | output | NG | Per-group executed flag |
| grp_crit | output | NG*LW | Per-group countdown, group g at bits g*LW +: LW |

## Verification
Several properties are checked on every cycle. The waiting/pending/ready classes never overlap or leave a gap. Executing and executed never coincide. An executed group stays executed until a member is added, and a flagged event leaves all flags unchanged. A countdown never rises without an issue or link event, an add to a linked group always raises the error, and `ev_ready` stays high once raised. Only the directed scenarios can show the release timing of the two kinds of link, the maximum latency carried to a data successor, the exact countdown steps, and that a duplicate link was truly not counted, seen when the target finally turns ready.

// File: rtl/mdg_pkg.sv
package mdg_pkg;
  typedef enum logic [1:0] {
    OP_ADD_INST = 2'd0,
    OP_LINK     = 2'd1,
    OP_ISSUE    = 2'd2,
    OP_DONE     = 2'd3
  } mdg_op_e;
endpackage

// File: rtl/mdg_event_check.sv
module mdg_event_check #(
  parameter int NG = 8,
  parameter int CW = 4,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic                   ev_valid,
  input  logic                   ev_ready,
  input  logic [1:0]             ev_op,
  input  logic [GW-1:0]          ev_grp,
  input  logic [GW-1:0]          ev_dst,
  input  logic                   ev_data,
  input  logic [NG-1:0][CW-1:0]  n_inst,
  input  logic [NG-1:0][CW-1:0]  n_iss,
  input  logic [NG-1:0][CW-1:0]  n_done,
  input  logic [NG-1:0][CW-1:0]  n_pred,
  input  logic [NG-1:0][NG-1:0]  links,
  input  logic [NG-1:0]          has_succ,
  input  logic [NG-1:0]          rdy_v,
  input  logic [NG-1:0]          exing_v,
  input  logic [NG-1:0]          exed_v,
  output logic [NG-1:0]          add_inst_v,
  output logic [NG-1:0]          issue_v,
  output logic [NG-1:0]          done_v,
  output logic [NG-1:0]          link_src_v,
  output logic [NG-1:0]          pred_add_v,
  output logic [NG-1:0]          pred_live_v,
  output logic [NG-1:0]          dst_oh,
  output logic                   err
);
  import mdg_pkg::*;

  localparam logic [CW-1:0] CMAX = '1;

  logic          acc, bad, skip, good;
  logic [NG-1:0] grp_oh;
  logic [CW:0]   used;
  mdg_op_e       op;

  assign op  = mdg_op_e'(ev_op);
  assign acc = ev_valid & ev_ready;

  always_comb begin
    grp_oh = '0;
    dst_oh = '0;
    grp_oh[ev_grp] = 1'b1;
    dst_oh[ev_dst] = 1'b1;
  end

  assign used = {1'b0, n_iss[ev_grp]} + {1'b0, n_done[ev_grp]};

  always_comb begin
    bad  = 1'b0;
    skip = 1'b0;
    unique case (op)
      OP_ADD_INST: bad = has_succ[ev_grp] | (n_inst[ev_grp] == CMAX);
      OP_LINK: begin
        skip = ~ev_data & exing_v[ev_grp];
        bad  = (ev_dst == ev_grp) | exed_v[ev_grp] | links[ev_grp][ev_dst] |
               (~skip & (n_pred[ev_dst] == CMAX));
      end
      OP_ISSUE: bad = ~rdy_v[ev_grp] | (used >= {1'b0, n_inst[ev_grp]});
      OP_DONE:  bad = (n_iss[ev_grp] == '0);
      default:  bad = 1'b1;
    endcase
  end

  assign err  = acc & bad;
  assign good = acc & ~bad;

  always_comb begin
    add_inst_v  = '0;
    issue_v     = '0;
    done_v      = '0;
    link_src_v  = '0;
    pred_add_v  = '0;
    pred_live_v = '0;
    if (good) begin
      unique case (op)
        OP_ADD_INST: add_inst_v = grp_oh;
        OP_ISSUE:    issue_v    = grp_oh;
        OP_DONE:     done_v     = grp_oh;
        OP_LINK: if (!skip) begin
          link_src_v = grp_oh;
          pred_add_v = dst_oh;
          if (exing_v[ev_grp]) pred_live_v = dst_oh;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mdg_group_cell.sv
module mdg_group_cell #(
  parameter int NG = 8,
  parameter int CW = 4,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_inst,
  input  logic          issue,
  input  logic          done,
  input  logic [LW-1:0] cyc_in,
  input  logic          link_set,
  input  logic [NG-1:0] link_dst,
  input  logic          link_data,
  input  logic          pred_add,
  input  logic          pred_live,
  input  logic          ord_rel,
  input  logic          dat_start,
  input  logic          dat_done,
  input  logic [LW-1:0] crit_src,
  output logic          waiting,
  output logic          pending,
  output logic          ready,
  output logic          executing,
  output logic          executed,
  output logic [CW-1:0] n_inst_o,
  output logic [CW-1:0] n_iss_o,
  output logic [CW-1:0] n_done_o,
  output logic [CW-1:0] n_pred_o,
  output logic [NG-1:0] succ_ord,
  output logic [NG-1:0] succ_dat,
  output logic          start_o,
  output logic          fin_o,
  output logic [LW-1:0] crit_next,
  output logic [LW-1:0] crit_o
);
  logic [CW-1:0] n_inst, n_iss, n_done, n_pred, n_pex, n_pdn;
  logic [LW-1:0] crit_mem, crit_pred;
  logic [CW:0]   pred_seen, left;
  logic          pex_inc;

  assign pred_seen = {1'b0, n_pex} + {1'b0, n_pdn};
  assign left      = {1'b0, n_inst} - {1'b0, n_done};

  assign waiting   = {1'b0, n_pred} > pred_seen;
  assign pending   = (n_pex != '0) && (pred_seen == {1'b0, n_pred});
  assign ready     = (n_pdn == n_pred);
  assign executing = (n_iss != '0) && ({1'b0, n_iss} == left);
  assign executed  = (n_done == n_inst);

  assign start_o   = issue && (({1'b0, n_iss} + 1'b1) == left);
  assign fin_o     = done && (({1'b0, n_done} + 1'b1) == {1'b0, n_inst});
  assign crit_next = (issue && cyc_in > crit_mem) ? cyc_in : crit_mem;
  assign pex_inc   = pred_live | dat_start;

  assign n_inst_o = n_inst;
  assign n_iss_o  = n_iss;
  assign n_done_o = n_done;
  assign n_pred_o = n_pred;
  assign crit_o   = crit_pred;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_inst    <= '0;
      n_iss     <= '0;
      n_done    <= '0;
      n_pred    <= '0;
      n_pex     <= '0;
      n_pdn     <= '0;
      succ_ord  <= '0;
      succ_dat  <= '0;
      crit_mem  <= '0;
      crit_pred <= '0;
    end else begin
      if (add_inst) n_inst <= n_inst + 1'b1;
      if (issue)    n_iss  <= n_iss + 1'b1;
      if (done) begin
        n_iss  <= n_iss - 1'b1;
        n_done <= n_done + 1'b1;
      end
      if (link_set) begin
        if (link_data) succ_dat <= succ_dat | link_dst;
        else           succ_ord <= succ_ord | link_dst;
      end
      if (pred_add) n_pred <= n_pred + 1'b1;
      n_pex <= n_pex + CW'(pex_inc) - CW'(dat_done);
      if (ord_rel | dat_done) n_pdn <= n_pdn + 1'b1;
      crit_mem <= fin_o ? '0 : crit_next;
      if (pex_inc) begin
        if (crit_src > crit_pred) crit_pred <= crit_src;
      end else if (waiting && crit_pred != '0) begin
        crit_pred <= crit_pred - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdg_scoreboard.sv
module mdg_scoreboard #(
  parameter int NG = 8,
  parameter int CW = 4,
  parameter int LW = 4,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [1:0]       ev_op,
  input  logic [GW-1:0]    ev_grp,
  input  logic [GW-1:0]    ev_dst,
  input  logic             ev_data,
  input  logic [LW-1:0]    ev_cycles,
  output logic             ev_err,
  output logic [NG-1:0]    grp_waiting,
  output logic [NG-1:0]    grp_pending,
  output logic [NG-1:0]    grp_ready,
  output logic [NG-1:0]    grp_executing,
  output logic [NG-1:0]    grp_executed,
  output logic [NG*LW-1:0] grp_crit
);
  logic [NG-1:0][CW-1:0] n_inst, n_iss, n_done, n_pred;
  logic [NG-1:0][NG-1:0] succ_ord, succ_dat, links;
  logic [NG-1:0][LW-1:0] crit_next;
  logic [NG-1:0]         has_succ, start_v, fin_v;
  logic [NG-1:0]         add_inst_v, issue_v, done_v, link_src_v, pred_add_v, pred_live_v, dst_oh;
  logic [NG-1:0]         ord_rel, dat_start, dat_done;
  logic [LW-1:0]         crit_src;
  logic                  rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign ev_ready = rdy_q;

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      links[g]    = succ_ord[g] | succ_dat[g];
      has_succ[g] = |links[g];
    end
  end

  mdg_event_check #(.NG(NG), .CW(CW)) u_dec (
    .ev_valid   (ev_valid),
    .ev_ready   (ev_ready),
    .ev_op      (ev_op),
    .ev_grp     (ev_grp),
    .ev_dst     (ev_dst),
    .ev_data    (ev_data),
    .n_inst     (n_inst),
    .n_iss      (n_iss),
    .n_done     (n_done),
    .n_pred     (n_pred),
    .links      (links),
    .has_succ   (has_succ),
    .rdy_v      (grp_ready),
    .exing_v    (grp_executing),
    .exed_v     (grp_executed),
    .add_inst_v (add_inst_v),
    .issue_v    (issue_v),
    .done_v     (done_v),
    .link_src_v (link_src_v),
    .pred_add_v (pred_add_v),
    .pred_live_v(pred_live_v),
    .dst_oh     (dst_oh),
    .err        (ev_err)
  );

  // Release fan-out: column j of each matrix collects the sources feeding group j.
  always_comb begin
    for (int j = 0; j < NG; j++) begin
      ord_rel[j]   = 1'b0;
      dat_start[j] = 1'b0;
      dat_done[j]  = 1'b0;
      for (int g = 0; g < NG; g++) begin
        ord_rel[j]   = ord_rel[j]   | (start_v[g] & succ_ord[g][j]);
        dat_start[j] = dat_start[j] | (start_v[g] & succ_dat[g][j]);
        dat_done[j]  = dat_done[j]  | (fin_v[g]   & succ_dat[g][j]);
      end
    end
  end

  assign crit_src = crit_next[ev_grp];

  for (genvar g = 0; g < NG; g++) begin : g_cell
    mdg_group_cell #(.NG(NG), .CW(CW), .LW(LW)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .add_inst  (add_inst_v[g]),
      .issue     (issue_v[g]),
      .done      (done_v[g]),
      .cyc_in    (ev_cycles),
      .link_set  (link_src_v[g]),
      .link_dst  (dst_oh),
      .link_data (ev_data),
      .pred_add  (pred_add_v[g]),
      .pred_live (pred_live_v[g]),
      .ord_rel   (ord_rel[g]),
      .dat_start (dat_start[g]),
      .dat_done  (dat_done[g]),
      .crit_src  (crit_src),
      .waiting   (grp_waiting[g]),
      .pending   (grp_pending[g]),
      .ready     (grp_ready[g]),
      .executing (grp_executing[g]),
      .executed  (grp_executed[g]),
      .n_inst_o  (n_inst[g]),
      .n_iss_o   (n_iss[g]),
      .n_done_o  (n_done[g]),
      .n_pred_o  (n_pred[g]),
      .succ_ord  (succ_ord[g]),
      .succ_dat  (succ_dat[g]),
      .start_o   (start_v[g]),
      .fin_o     (fin_v[g]),
      .crit_next (crit_next[g]),
      .crit_o    (grp_crit[g*LW +: LW])
    );
  end
endmodule

// File: rtl/mdg_scoreboard_chk.sv
module mdg_scoreboard_chk #(
  parameter int NG = 8,
  parameter int LW = 4,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic [1:0]       ev_op,
  input logic [GW-1:0]    ev_grp,
  input logic             ev_err,
  input logic [NG-1:0]    has_succ,
  input logic [NG-1:0]    add_inst_v,
  input logic [NG-1:0]    grp_waiting,
  input logic [NG-1:0]    grp_pending,
  input logic [NG-1:0]    grp_ready,
  input logic [NG-1:0]    grp_executing,
  input logic [NG-1:0]    grp_executed,
  input logic [NG*LW-1:0] grp_crit
);
  logic          acc, crit_ev;
  logic [NG-1:0] exed_q;
  logic          q_vld;

  assign acc     = ev_valid & ev_ready;
  assign crit_ev = acc & (ev_op == 2'd1 || ev_op == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exed_q <= '0;
      q_vld  <= 1'b0;
    end else begin
      exed_q <= grp_executed & ~add_inst_v;
      q_vld  <= 1'b1;
    end
  end

  // R2: the three predecessor classes partition the groups
  a_r2_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    ((grp_waiting & grp_pending) == '0) && ((grp_waiting & grp_ready) == '0) &&
    ((grp_pending & grp_ready) == '0) && ((grp_waiting | grp_pending | grp_ready) == '1));

  a_r3_exec_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_executing & grp_executed) == '0);

  a_r3_executed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld |-> ((exed_q & ~grp_executed) == '0));

  a_r8_add_linked: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ev_op == 2'd0 && has_succ[ev_grp]) |-> ev_err);

  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> ($stable(grp_waiting) && $stable(grp_pending) && $stable(grp_ready) &&
                $stable(grp_executing) && $stable(grp_executed)));

  a_r12_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready |=> ev_ready);

  for (genvar g = 0; g < NG; g++) begin : g_crit
    a_r10_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !crit_ev |=> (grp_crit[g*LW +: LW] <= $past(grp_crit[g*LW +: LW])));
  end
endmodule

bind mdg_scoreboard mdg_scoreboard_chk #(.NG(NG), .LW(LW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_valid     (ev_valid),
  .ev_ready     (ev_ready),
  .ev_op        (ev_op),
  .ev_grp       (ev_grp),
  .ev_err       (ev_err),
  .has_succ     (has_succ),
  .add_inst_v   (add_inst_v),
  .grp_waiting  (grp_waiting),
  .grp_pending  (grp_pending),
  .grp_ready    (grp_ready),
  .grp_executing(grp_executing),
  .grp_executed (grp_executed),
  .grp_crit     (grp_crit)
);

// File: tb/mdg_scoreboard_tb.sv
module mdg_scoreboard_tb;
  localparam int NG = 8;
  localparam int LW = 4;
  localparam int GW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [1:0] ev_op = '0;
  logic [GW-1:0] ev_grp = '0, ev_dst = '0;
  logic ev_data = 1'b0;
  logic [LW-1:0] ev_cycles = '0;
  logic ev_ready, ev_err;
  logic [NG-1:0] w, p, r, ex, ed;
  logic [NG*LW-1:0] crit;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mdg_scoreboard u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_op(ev_op), .ev_grp(ev_grp), .ev_dst(ev_dst), .ev_data(ev_data),
    .ev_cycles(ev_cycles), .ev_err(ev_err), .grp_waiting(w), .grp_pending(p),
    .grp_ready(r), .grp_executing(ex), .grp_executed(ed), .grp_crit(crit)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one event at a falling edge, check the error flag, return after the commit edge.
  task automatic send(input int op, input int g, input int d, input bit dat,
                      input int cyc, input bit exp_err, input string req);
    @(negedge clk);
    ev_valid = 1'b1; ev_op = op[1:0]; ev_grp = g[GW-1:0]; ev_dst = d[GW-1:0];
    ev_data = dat; ev_cycles = cyc[LW-1:0];
    #1 chk(req, int'(ev_err), int'(exp_err));
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  function automatic int crit_of(input int g);
    return int'(crit[g*LW +: LW]);
  endfunction

  task automatic t_reset;
    chk("R1 ready low in reset", int'(ev_ready), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(ev_ready), 1);
    chk("R1 ready mask", int'(r), 8'hFF);
    chk("R1 executed mask", int'(ed), 8'hFF);
    chk("R1 waiting mask", int'(w), 0);
    chk("R1 pending mask", int'(p), 0);
    chk("R1 executing mask", int'(ex), 0);
    chk("R1 crit", int'(crit), 0);
  endtask

  task automatic t_order;
    send(0, 0, 0, 0, 0, 0, "R12 add g0");
    chk("R3 g0 not executed", int'(ed[0]), 0);
    send(0, 1, 0, 0, 0, 0, "R12 add g1");
    send(1, 0, 1, 0, 0, 0, "R12 order link");
    chk("R2 g1 waiting", int'(w[1]), 1);
    send(2, 0, 0, 0, 2, 0, "R12 issue g0");
    chk("R3 g0 executing", int'(ex[0]), 1);
    chk("R4 g1 ready", int'(r[1]), 1);
    chk("R4 g1 not pending", int'(p[1]), 0);
    send(3, 0, 0, 0, 0, 0, "R12 done g0");
    chk("R3 g0 executed", int'(ed[0]), 1);
  endtask

  task automatic t_data;
    send(0, 2, 0, 0, 0, 0, "R12 add g2");
    send(0, 2, 0, 0, 0, 0, "R12 add g2");
    send(0, 3, 0, 0, 0, 0, "R12 add g3");
    send(1, 2, 3, 1, 0, 0, "R12 data link");
    send(2, 2, 0, 0, 3, 0, "R12 issue g2 a");
    chk("R3 partial not executing", int'(ex[2]), 0);
    chk("R5 g3 still waiting", int'(w[3]), 1);
    send(2, 2, 0, 0, 7, 0, "R12 issue g2 b");
    chk("R3 g2 executing", int'(ex[2]), 1);
    chk("R5 g3 pending", int'(p[3]), 1);
    chk("R11 g3 crit max", crit_of(3), 7);
    send(3, 2, 0, 0, 0, 0, "R12 done g2 a");
    chk("R5 g3 pending after one", int'(p[3]), 1);
    send(3, 2, 0, 0, 0, 0, "R12 done g2 b");
    chk("R5 g3 ready", int'(r[3]), 1);
    chk("R10 crit held when not waiting", crit_of(3), 7);
  endtask

  task automatic t_late;
    send(0, 4, 0, 0, 0, 0, "R12 add g4");
    send(2, 4, 0, 0, 4, 0, "R12 issue g4");
    send(0, 5, 0, 0, 0, 0, "R12 add g5");
    send(1, 4, 5, 0, 0, 0, "R6 order late no err");
    chk("R6 g5 still ready", int'(r[5]), 1);
    send(1, 4, 5, 1, 0, 0, "R7 data late no err");
    chk("R7 g5 pending", int'(p[5]), 1);
    chk("R7 g5 crit", crit_of(5), 4);
    send(3, 4, 0, 0, 0, 0, "R12 done g4");
    chk("R5 g5 ready", int'(r[5]), 1);
  endtask

  task automatic t_illegal;
    send(0, 0, 0, 0, 0, 1, "R8 add to linked group");
    chk("R8 g0 still executed", int'(ed[0]), 1);
    send(1, 6, 6, 0, 0, 1, "R9 self link");
    send(0, 6, 0, 0, 0, 0, "R12 add g6");
    send(0, 7, 0, 0, 0, 0, "R12 add g7");
    send(1, 6, 7, 0, 0, 0, "R12 order g6-g7");
    send(1, 6, 7, 1, 0, 1, "R9 duplicate link");
    send(2, 7, 0, 0, 1, 1, "R9 issue not ready");
    send(3, 7, 0, 0, 0, 1, "R9 done nothing issued");
    send(1, 2, 7, 0, 0, 1, "R9 link from executed");
    send(2, 2, 0, 0, 1, 1, "R9 issue nothing left");
  endtask

  task automatic t_countdown;
    send(1, 1, 7, 1, 0, 0, "R12 data g1-g7");
    send(2, 1, 0, 0, 5, 0, "R12 issue g1");
    chk("R10 g7 waiting", int'(w[7]), 1);
    chk("R11 g7 crit loaded", crit_of(7), 5);
    repeat (2) @(negedge clk);
    chk("R10 g7 crit after two", crit_of(7), 3);
    repeat (8) @(negedge clk);
    chk("R10 g7 crit floor", crit_of(7), 0);
    send(2, 6, 0, 0, 0, 0, "R12 issue g6");
    chk("R2 g7 pending", int'(p[7]), 1);
    send(3, 1, 0, 0, 0, 0, "R12 done g1");
    chk("R9 g7 ready so duplicate dropped", int'(r[7]), 1);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 14; i++) send(0, 3, 0, 0, 0, 0, "R9 fill g3");
    send(0, 3, 0, 0, 0, 1, "R9 member overflow");
    chk("R9 g3 not executed", int'(ed[3]), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_order();
    t_data();
    t_late();
    t_illegal();
    t_countdown();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule